// File: doc/BRIEF.md
# Reference Selector and Operating-Mode Controller

This block decides which of several incoming reference clocks a network-element timing unit follows. It also decides which operating mode the timing loop is in. Each reference arrives with a good/fault flag from an upstream quality monitor and a software-programmed priority. Every cycle the block picks the best eligible reference. When the active reference fails, or a better one becomes usable, it moves to the new choice immediately, so the downstream loop never runs without an input while a qualified alternative exists.

Alongside selection, a mode machine steps through free-run, acquisition, locked and holdover. Acquisition is left for locked only after the phase-lock indication from the loop has held for a programmable run of consecutive cycles. If all references are lost while locked, the block enters holdover and emits a one-cycle freeze strobe, so the loop filter holds its last frequency. Holdover is never left for free-run automatically. A force control lets software impose any mode at any time, taking priority over the automatic path. A sticky flag records each move to a new selected reference, and software clears it by writing a one.

Top module: `refsel_mode_ctrl`

## Requirements
- R1: After reset, `mode` is free-run and `sel_valid`, `freeze` and `switch_flag` are all low. The mode codes are: free-run = 0, locked = 1, holdover = 2, acquiring = 3.
- R2: A reference is eligible only when its `ref_good` bit is high and its priority field is non-zero. With no eligible reference, `sel_valid` is low one cycle later.
- R3: Reference i's priority sits in `prio_tbl[4*i+3:4*i]`. The eligible reference with the smallest non-zero value is selected, and equal values go to the lower index. Selection is re-evaluated every cycle, including reverting to a better reference that returns, and `sel_idx`/`sel_valid` show the result one cycle after the inputs.
- R4: While locked, moving the selection from one eligible reference to another keeps `mode` locked.
- R5: Free-run or holdover with a valid selection moves to acquiring on the next cycle. Acquiring moves to locked once `lock_ind` has been high for `lock_len` consecutive cycles, where a `lock_len` of 0 counts as 1. Any low cycle of `lock_ind` restarts the count.
- R6: Locked with no valid selection moves to holdover. `freeze` is high for exactly the first cycle of any holdover period.
- R7: Holdover is kept until a valid selection returns (then acquiring) or software forces a mode. It never changes to free-run by itself.
- R8: Losing the selection while acquiring leads to holdover if locked has been reached since the last forced free-run, and to free-run otherwise.
- R9: While `force_en` is high, `mode` equals `force_mode` from the next cycle on, whatever the automatic conditions are. Forcing free-run erases the lock history used by R8.
- R10: `switch_flag` is set when the selection becomes valid on a reference different from the previous selection, or valid after none. Loss of all references does not set it. A high `flag_clr` clears it, but a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_good | input | N_REF | Quality-monitor good flag per reference |
| prio_tbl | input | N_REF*PRIO_W | Packed priority fields, 0 = disabled |
| lock_len | input | CNT_W | Consecutive lock cycles required for locked |
| lock_ind | input | 1 | Phase-lock indication from the loop |
| force_en | input | 1 | Enable software mode forcing |
| force_mode | input | 2 | Mode code to force |
| flag_clr | input | 1 | Write-one-to-clear for the switch flag |
| sel_idx | output | IDX_W | Selected reference index |
| sel_valid | output | 1 | A reference is selected |
| mode | output | 2 | Current operating mode code |
| freeze | output | 1 | One-cycle holdover entry strobe |
| switch_flag | output | 1 | Sticky selection-change flag |

## Verification
The bench builds the block with four references, 4-bit priority fields and a 4-bit lock counter. With these values every field of the priority table and the full lock-length range can be exercised in a short run. It runs with a lock length of 3, which is long enough to show a count restarted by a dropped lock cycle, and then with 0 to show the treat-as-one rule. The sequences cover the priority tie, a disabled input that is good, revertive selection, and both outcomes of losing a reference during acquisition. They also cover forcing from holdover and the case where a flag set and a flag clear arrive in the same cycle.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_LOCKED = 2'd1,
    MODE_HOLD   = 2'd2,
    MODE_ACQ    = 2'd3
  } mode_e;

  // True when one more lock cycle on top of 'count' meets the required run.
  function automatic logic lock_reached(input int unsigned count, input int unsigned len);
    return (count + 1) >= len;
  endfunction

  // True when priority 'a' beats the current best 'b' (strictly smaller, non-zero).
  function automatic logic prio_better(input int unsigned a, input int unsigned b, input logic have_best);
    return (a != 0) && (!have_best || a < b);
  endfunction

endpackage

// File: rtl/refsel_arbiter.sv
module refsel_arbiter #(
  parameter int N_REF  = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic [N_REF-1:0]        ref_good,
  input  logic [N_REF*PRIO_W-1:0] prio_tbl,
  output logic [IDX_W-1:0]        best_idx,
  output logic                    best_valid
);
  import refsel_pkg::*;

  logic [N_REF-1:0] elig;

  for (genvar g = 0; g < N_REF; g++) begin : g_elig
    assign elig[g] = ref_good[g] && (prio_tbl[g*PRIO_W +: PRIO_W] != '0);
  end

  // Ascending scan with a strict compare keeps ties on the lower index.
  always_comb begin
    logic [PRIO_W-1:0] best_p;
    best_p     = '0;
    best_idx   = '0;
    best_valid = 1'b0;
    for (int i = 0; i < N_REF; i++) begin
      if (elig[i] && prio_better(32'(prio_tbl[i*PRIO_W +: PRIO_W]), 32'(best_p), best_valid)) begin
        best_p     = prio_tbl[i*PRIO_W +: PRIO_W];
        best_idx   = IDX_W'(i);
        best_valid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/refsel_lock_qual.sv
module refsel_lock_qual #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lock_ind,
  input  logic [CNT_W-1:0] lock_len,
  output logic             done
);
  import refsel_pkg::*;

  logic [CNT_W-1:0] cnt;

  assign done = run && lock_ind && lock_reached(32'(cnt), 32'(lock_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || !lock_ind) begin
      cnt <= '0;
    end else if (!done && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/refsel_mode_fsm.sv
module refsel_mode_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_valid,
  input  logic       lock_done,
  input  logic       force_en,
  input  logic [1:0] force_mode,
  output refsel_pkg::mode_e mode,
  output logic       enter_hold,
  output logic       freeze
);
  import refsel_pkg::*;

  mode_e nxt;
  logic  had_lock;

  always_comb begin
    nxt = mode;
    if (force_en) begin
      nxt = mode_e'(force_mode);
    end else begin
      unique case (mode)
        MODE_FREE:   if (sel_valid) nxt = MODE_ACQ;
        MODE_ACQ: begin
          if (!sel_valid)     nxt = had_lock ? MODE_HOLD : MODE_FREE;
          else if (lock_done) nxt = MODE_LOCKED;
        end
        MODE_LOCKED: if (!sel_valid) nxt = MODE_HOLD;
        MODE_HOLD:   if (sel_valid) nxt = MODE_ACQ;
        default:     nxt = MODE_FREE;
      endcase
    end
  end

  assign enter_hold = (nxt == MODE_HOLD) && (mode != MODE_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_FREE;
      had_lock <= 1'b0;
      freeze   <= 1'b0;
    end else begin
      mode   <= nxt;
      freeze <= enter_hold;
      if (force_en && mode_e'(force_mode) == MODE_FREE) had_lock <= 1'b0;
      else if (nxt == MODE_LOCKED)                      had_lock <= 1'b1;
    end
  end

endmodule

// File: rtl/refsel_mode_ctrl.sv
module refsel_mode_ctrl #(
  parameter int N_REF  = 4,
  parameter int PRIO_W = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REF-1:0]        ref_good,
  input  logic [N_REF*PRIO_W-1:0] prio_tbl,
  input  logic [CNT_W-1:0]        lock_len,
  input  logic                    lock_ind,
  input  logic                    force_en,
  input  logic [1:0]              force_mode,
  input  logic                    flag_clr,
  output logic [IDX_W-1:0]        sel_idx,
  output logic                    sel_valid,
  output logic [1:0]              mode,
  output logic                    freeze,
  output logic                    switch_flag
);
  import refsel_pkg::*;

  logic [IDX_W-1:0] best_idx;
  logic             best_valid;
  logic             sel_change;
  logic             lock_done;
  logic             enter_hold;
  logic             acq_run;
  mode_e            mode_q;

  refsel_arbiter #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_arb (
    .ref_good   (ref_good),
    .prio_tbl   (prio_tbl),
    .best_idx   (best_idx),
    .best_valid (best_valid)
  );

  assign sel_change = best_valid && (!sel_valid || best_idx != sel_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx     <= '0;
      sel_valid   <= 1'b0;
      switch_flag <= 1'b0;
    end else begin
      sel_valid <= best_valid;
      if (best_valid) sel_idx <= best_idx;
      if (sel_change)    switch_flag <= 1'b1;
      else if (flag_clr) switch_flag <= 1'b0;
    end
  end

  assign acq_run = (mode_q == MODE_ACQ) && sel_valid;

  refsel_lock_qual #(.CNT_W(CNT_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (acq_run),
    .lock_ind (lock_ind),
    .lock_len (lock_len),
    .done     (lock_done)
  );

  refsel_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_valid  (sel_valid),
    .lock_done  (lock_done),
    .force_en   (force_en),
    .force_mode (force_mode),
    .mode       (mode_q),
    .enter_hold (enter_hold),
    .freeze     (freeze)
  );

  assign mode = mode_q;

endmodule

// File: rtl/refsel_mode_ctrl_chk.sv
module refsel_mode_ctrl_chk #(
  parameter int N_REF  = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REF-1:0]        ref_good,
  input logic [N_REF*PRIO_W-1:0] prio_tbl,
  input logic                    lock_ind,
  input logic                    force_en,
  input logic [1:0]              force_mode,
  input logic [IDX_W-1:0]        sel_idx,
  input logic                    sel_valid,
  input logic [1:0]              mode,
  input logic                    freeze,
  input logic                    switch_flag,
  input logic                    sel_change
);
  logic [N_REF-1:0] elig_q;

  for (genvar g = 0; g < N_REF; g++) begin : g_eq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) elig_q[g] <= 1'b0;
      else        elig_q[g] <= ref_good[g] && (prio_tbl[g*PRIO_W +: PRIO_W] != '0);
    end
  end

  assert_sel_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig_q[sel_idx]);

  assert_lock_needs_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd3 && !$past(force_en)) |-> $past(lock_ind));

  assert_freeze_on_hold_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (mode == 2'd2 && $past(mode) != 2'd2));

  assert_lock_exit_to_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd1 && !$past(force_en) && mode != 2'd1) |-> mode == 2'd2);

  assert_hold_no_auto_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && mode == 2'd0) |-> $past(force_en));

  assert_force_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> mode == $past(force_mode));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> switch_flag);

endmodule

bind refsel_mode_ctrl refsel_mode_ctrl_chk #(.N_REF(N_REF), .PRIO_W(PRIO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_good    (ref_good),
  .prio_tbl    (prio_tbl),
  .lock_ind    (lock_ind),
  .force_en    (force_en),
  .force_mode  (force_mode),
  .sel_idx     (sel_idx),
  .sel_valid   (sel_valid),
  .mode        (mode),
  .freeze      (freeze),
  .switch_flag (switch_flag),
  .sel_change  (sel_change)
);

// File: tb/test_refsel_mode_ctrl.sv
module test_refsel_mode_ctrl;
  localparam int N_REF = 4, PRIO_W = 4, CNT_W = 4;
  localparam logic [1:0] FR = 2'd0, LK = 2'd1, HO = 2'd2, AQ = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_REF-1:0] ref_good = '0;
  logic [N_REF*PRIO_W-1:0] prio_tbl = '0;
  logic [CNT_W-1:0] lock_len = 4'd3;
  logic lock_ind = 1'b0, force_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] force_mode = 2'd0;
  logic [1:0] sel_idx, mode;
  logic sel_valid, freeze, switch_flag;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [1:0] mode;
    logic       valid;
    logic [1:0] idx;
    logic       flag;
    logic       frz;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  refsel_mode_ctrl #(.N_REF(N_REF), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) i_refsel_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_good(ref_good), .prio_tbl(prio_tbl),
    .lock_len(lock_len), .lock_ind(lock_ind), .force_en(force_en),
    .force_mode(force_mode), .flag_clr(flag_clr), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .mode(mode), .freeze(freeze), .switch_flag(switch_flag)
  );

  // Driver side: wait n edges, then queue what the outputs must show.
  task automatic chk(input int n, input string req, input logic [1:0] m, input logic v,
                     input logic [1:0] idx, input logic f, input logic z);
    exp_t e;
    repeat (n) @(posedge clk);
    e.req = req; e.mode = m; e.valid = v; e.idx = idx; e.flag = f; e.frz = z;
    sb.push_back(e);
  endtask

  // Monitor: compare queued items at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (mode !== e.mode || sel_valid !== e.valid || switch_flag !== e.flag ||
            freeze !== e.frz || (e.valid && sel_idx !== e.idx)) begin
          errors++;
          $display("FAIL %s: mode=%0d valid=%0b idx=%0d flag=%0b frz=%0b expected mode=%0d valid=%0b idx=%0d flag=%0b frz=%0b",
                   e.req, mode, sel_valid, sel_idx, switch_flag, freeze,
                   e.mode, e.valid, e.idx, e.flag, e.frz);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // ref3=0 (disabled), ref2=2, ref1=2, ref0=5
    prio_tbl = {4'd0, 4'd2, 4'd2, 4'd5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, "R1", FR, 0, 0, 0, 0);

    @(negedge clk) ref_good = 4'b1000;              // good but disabled
    chk(2, "R2", FR, 0, 0, 0, 0);

    @(negedge clk) begin ref_good = 4'b1111; lock_ind = 1'b0; end
    chk(1, "R3", FR, 1, 1, 1, 0);                   // tie ref1/ref2 -> ref1
    chk(1, "R5", AQ, 1, 1, 1, 0);
    chk(4, "R5", AQ, 1, 1, 1, 0);                   // no lock indication
    @(negedge clk) lock_ind = 1'b1;
    chk(2, "R5", AQ, 1, 1, 1, 0);
    chk(1, "R5", LK, 1, 1, 1, 0);

    @(negedge clk) flag_clr = 1'b1;
    chk(1, "R10", LK, 1, 1, 0, 0);
    @(negedge clk) begin flag_clr = 1'b0; ref_good = 4'b1101; end
    chk(1, "R4", LK, 1, 2, 1, 0);
    chk(3, "R4", LK, 1, 2, 1, 0);

    @(negedge clk) flag_clr = 1'b1;
    chk(1, "R10", LK, 1, 2, 0, 0);
    @(negedge clk) begin flag_clr = 1'b0; ref_good = 4'b1000; end
    chk(1, "R10", LK, 0, 0, 0, 0);                  // loss does not set flag
    chk(1, "R6", HO, 0, 0, 0, 1);
    chk(1, "R6", HO, 0, 0, 0, 0);
    chk(6, "R7", HO, 0, 0, 0, 0);

    @(negedge clk) ref_good = 4'b1001;
    chk(1, "R7", HO, 1, 0, 1, 0);
    chk(1, "R7", AQ, 1, 0, 1, 0);
    chk(2, "R5", AQ, 1, 0, 1, 0);
    chk(1, "R5", LK, 1, 0, 1, 0);

    @(negedge clk) ref_good = 4'b1011;              // better ref1 returns
    chk(1, "R3", LK, 1, 1, 1, 0);

    @(negedge clk) begin force_en = 1'b1; force_mode = FR; end
    chk(1, "R9", FR, 1, 1, 1, 0);
    chk(3, "R9", FR, 1, 1, 1, 0);
    @(negedge clk) force_en = 1'b0;
    chk(1, "R5", AQ, 1, 1, 1, 0);
    chk(1, "R5", AQ, 1, 1, 1, 0);
    @(negedge clk) lock_ind = 1'b0;                 // break the run
    chk(1, "R5", AQ, 1, 1, 1, 0);
    @(negedge clk) lock_ind = 1'b1;
    chk(2, "R5", AQ, 1, 1, 1, 0);
    chk(1, "R5", LK, 1, 1, 1, 0);

    @(negedge clk) begin lock_ind = 1'b0; force_en = 1'b1; force_mode = FR; end
    chk(1, "R9", FR, 1, 1, 1, 0);
    @(negedge clk) force_en = 1'b0;
    chk(1, "R8", AQ, 1, 1, 1, 0);
    @(negedge clk) ref_good = 4'b0000;
    chk(1, "R8", AQ, 0, 0, 1, 0);
    chk(1, "R8", FR, 0, 0, 1, 0);                   // no lock history

    @(negedge clk) ref_good = 4'b0100;
    chk(1, "R5", FR, 1, 2, 1, 0);
    chk(1, "R5", AQ, 1, 2, 1, 0);
    @(negedge clk) lock_ind = 1'b1;
    chk(2, "R5", AQ, 1, 2, 1, 0);
    chk(1, "R5", LK, 1, 2, 1, 0);
    @(negedge clk) ref_good = 4'b0000;
    chk(1, "R6", LK, 0, 0, 1, 0);
    chk(1, "R6", HO, 0, 0, 1, 1);
    @(negedge clk) begin ref_good = 4'b0100; lock_ind = 1'b0; end
    chk(1, "R7", HO, 1, 2, 1, 0);
    chk(1, "R7", AQ, 1, 2, 1, 0);
    @(negedge clk) ref_good = 4'b0000;
    chk(1, "R8", AQ, 0, 0, 1, 0);
    chk(1, "R8", HO, 0, 0, 1, 1);                   // lock history kept

    @(negedge clk) begin force_en = 1'b1; force_mode = LK; end
    chk(1, "R9", LK, 0, 0, 1, 0);
    @(negedge clk) force_mode = HO;
    chk(1, "R9", HO, 0, 0, 1, 1);
    @(negedge clk) begin force_en = 1'b0; flag_clr = 1'b1; end
    chk(1, "R10", HO, 0, 0, 0, 0);
    @(negedge clk) ref_good = 4'b0001;              // set wins over clear
    chk(1, "R10", HO, 1, 0, 1, 0);

    @(negedge clk) begin flag_clr = 1'b0; lock_len = 4'd0; lock_ind = 1'b1; end
    chk(1, "R5", AQ, 1, 0, 1, 0);
    chk(1, "R5", LK, 1, 0, 1, 0);                   // length 0 acts as 1

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule